// File: doc/BRIEF.md
# Weekly Alarm Clock Controller

This block keeps wall-clock time as hours, minutes and seconds in packed BCD and counts in 24-hour form. It advances once for each pulse on a one-pulse-per-second input. Seven alarm times are held, one for each day of the week. On each second, the alarm for the day given by a day-of-week input is compared with the clock. When the alarm function is armed and the two match, the block raises a tone-enable output and a relay output. An external tone generator and a switched load use these.

Cancelling is done in two stages. The first stop press mutes the tone but keeps the relay. A second stop press drops the relay. A start press closes the relay without any sound. A snooze press mutes a ringing alarm, and the tone comes back after a delay of 180 seconds plus 0 to 15 seconds of jitter. The jitter is drawn from a free-running shift register. Button inputs arrive already debounced, and their active level is set by a parameter. The arm input is either a momentary button that toggles the armed state or a latching switch whose level is used directly. One load port sets either the clock or any of the seven alarms.

Top module: `wk_alarm_ctrl`

## Requirements
- R1: The clock counts seconds 00-59, minutes 00-59 and hours 00-23 in packed BCD (tens in bits 7:4, units in bits 3:0). It advances by one second on the clock edge that samples `sec_tick` high. 23:59:59 is followed by 00:00:00. After reset the clock reads 00:00:00.
- R2: When `ld_valid` is high and `ld_slot` is 7, the clock takes `ld_hh:ld_mm:ld_ss` at that edge. A load takes priority over a tick sampled at the same edge.
- R3: When `ld_valid` is high and `ld_slot` is 0 to 6, the alarm of that day is written. Only the alarm selected by `day_of_week` (0 to 6) can fire. `day_of_week` = 7 selects no alarm.
- R4: If the block is armed and, after a tick, the clock equals the selected alarm, then `tone_en` and `relay_out` are both high from the second edge after the tick was sampled. Both are low after reset.
- R5: `relay_out` stays high until a stop press clears it.
- R6: A stop press while the tone sounds or a snooze is pending mutes the tone, cancels the snooze and keeps the relay. A stop press while the tone is silent and no snooze is pending clears the relay.
- R7: A start press sets `relay_out` and leaves `tone_en` unchanged.
- R8: A snooze press while the tone sounds mutes it. The tone comes back after 180 + j further ticks, where j is 0 to 15 and the relay stays high throughout. A snooze press while the tone is silent has no effect.
- R9: With `BTN_ACTIVE_LOW` = 1 every button and the arm input count as pressed when low. With 0 they count as pressed when high. A press acts on the edge that first samples it active.
- R10: With `ARM_LATCHING` = 0 each arm press toggles `armed`, which resets to 0. With 1, `armed` follows the active level of `arm_in` one edge later. While `armed` is 0 no alarm fires.
- R11: The alarm comparison is made only on seconds that were counted by a tick. Loading the clock with a value equal to the alarm does not fire it.
- R12: Any load cancels a pending snooze, and the tone then does not come back by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| btn_stop | input | 1 | Stop button pulse |
| btn_snooze | input | 1 | Snooze button pulse |
| btn_start | input | 1 | Start (relay on) button pulse |
| arm_in | input | 1 | Arm button or switch |
| day_of_week | input | 3 | Current day 0-6; 7 = no day |
| ld_valid | input | 1 | Load strobe |
| ld_slot | input | 3 | 0-6 alarm of that day, 7 clock |
| ld_hh | input | 8 | Load hours, BCD |
| ld_mm | input | 8 | Load minutes, BCD |
| ld_ss | input | 8 | Load seconds, BCD |
| tone_en | output | 1 | Tone generator enable |
| relay_out | output | 1 | Relay drive, held |
| armed | output | 1 | Alarm function armed |
| now_hh | output | 8 | Current hours, BCD |
| now_mm | output | 8 | Current minutes, BCD |
| now_ss | output | 8 | Current seconds, BCD |

## Verification
The clock digits change one edge after a sampled tick or load. The tone and the relay react to a match two edges after the tick, because the match is tested in the cycle after the clock has moved. Button effects and the latched arm level appear one edge after the input is sampled. Every stimulus task in the bench drives its inputs on a falling edge, lets at least two rising edges pass, and then samples on a falling edge, so each result is read after its last register has settled. The snooze return is checked as a window: the tone must still be off after 179 ticks and must be back by tick 195.

// File: rtl/wk_alarm_pkg.sv
`timescale 1ns/1ps
package wk_alarm_pkg;

    localparam int WK_DAYS   = 7;
    localparam int WK_SLOT_W = $clog2(WK_DAYS + 1);
    localparam logic [WK_SLOT_W-1:0] WK_SLOT_CLOCK = WK_SLOT_W'(WK_DAYS);
    localparam int WK_NBTN   = 4;

    typedef enum int unsigned {
        BTN_STOP   = 0,
        BTN_SNOOZE = 1,
        BTN_START  = 2,
        BTN_ARM    = 3
    } btn_idx_e;

    typedef struct packed {
        logic [7:0] hh;
        logic [7:0] mm;
        logic [7:0] ss;
    } hms_t;

    typedef struct packed {
        logic       carry;
        logic [7:0] val;
    } bcd_step_t;

    // One BCD digit pair step; wraps to 00 after 'last'.
    function automatic bcd_step_t bcd_step(input logic [7:0] v, input logic [7:0] last);
        bcd_step_t r;
        if (v == last) begin
            r.carry = 1'b1;
            r.val   = 8'h00;
        end else if (v[3:0] == 4'd9) begin
            r.carry = 1'b0;
            r.val   = {v[7:4] + 4'd1, 4'd0};
        end else begin
            r.carry = 1'b0;
            r.val   = {v[7:4], v[3:0] + 4'd1};
        end
        return r;
    endfunction

endpackage

// File: rtl/wk_btn_cond.sv
`timescale 1ns/1ps
module wk_btn_cond #(
    parameter int N          = 4,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    output logic [N-1:0] press
);
    logic [N-1:0] level;
    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        assign level[g] = raw[g] ^ ACTIVE_LOW;
        assign press[g] = level[g] & ~prev_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level;
    end

    // R9: a press is a single-cycle event
    a_r9_press_single: assert property (@(posedge clk) disable iff (rst)
        press[0] |=> !press[0]);

endmodule

// File: rtl/wk_timekeeper.sv
`timescale 1ns/1ps
module wk_timekeeper
    import wk_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic ld_en,
    input  hms_t ld_val,
    output hms_t now,
    output logic sec_upd
);
    hms_t      now_q;
    hms_t      nxt;
    bcd_step_t s_st, m_st, h_st;

    always_comb begin
        s_st = bcd_step(now_q.ss, 8'h59);
        m_st = s_st.carry ? bcd_step(now_q.mm, 8'h59) : '{carry: 1'b0, val: now_q.mm};
        h_st = m_st.carry ? bcd_step(now_q.hh, 8'h23) : '{carry: 1'b0, val: now_q.hh};
        nxt  = '{hh: h_st.val, mm: m_st.val, ss: s_st.val};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            now_q   <= '0;
            sec_upd <= 1'b0;
        end else begin
            sec_upd <= 1'b0;
            if (ld_en) begin
                now_q <= ld_val;
            end else if (tick) begin
                now_q   <= nxt;
                sec_upd <= 1'b1;
            end
        end
    end

    assign now = now_q;

    // R1: midnight rollover
    a_r1_midnight_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && !ld_en && now_q == 24'h235959) |=> (now_q == 24'h000000));
    // R1: a counted tick always moves the seconds
    a_r1_second_moves: assert property (@(posedge clk) disable iff (rst)
        (tick && !ld_en) |=> (now_q.ss != $past(now_q.ss)));
    // R2: a load overrides a tick
    a_r2_load_wins: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> (now_q == $past(ld_val) && !sec_upd));

endmodule

// File: rtl/wk_alarm_bank.sv
`timescale 1ns/1ps
module wk_alarm_bank
    import wk_alarm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ld_en,
    input  logic [WK_SLOT_W-1:0] ld_slot,
    input  hms_t                 ld_val,
    input  logic [WK_SLOT_W-1:0] day,
    output hms_t                 today,
    output logic                 today_ok
);
    hms_t bank_q [WK_DAYS];

    for (genvar d = 0; d < WK_DAYS; d++) begin : g_day
        always_ff @(posedge clk) begin
            if (rst)                                         bank_q[d] <= '0;
            else if (ld_en && ld_slot == WK_SLOT_W'(d))      bank_q[d] <= ld_val;
        end
    end

    always_comb begin
        today    = '0;
        today_ok = 1'b0;
        for (int d = 0; d < WK_DAYS; d++) begin
            if (day == WK_SLOT_W'(d)) begin
                today    = bank_q[d];
                today_ok = 1'b1;
            end
        end
    end

    // R3: the no-day code never selects an alarm
    a_r3_no_day: assert property (@(posedge clk) disable iff (rst)
        (day == WK_SLOT_CLOCK) |-> !today_ok);

endmodule

// File: rtl/wk_ring_ctl.sv
`timescale 1ns/1ps
module wk_ring_ctl
    import wk_alarm_pkg::*;
#(
    parameter int                SNOOZE_BASE = 180,
    parameter int                JIT_W       = 4,
    parameter int                LFSR_W      = 8,
    parameter logic [LFSR_W-1:0] LFSR_TAPS   = 'hB8
) (
    input  logic clk,
    input  logic rst,
    input  logic sec_upd,
    input  logic armed,
    input  logic today_ok,
    input  hms_t today,
    input  hms_t now,
    input  logic stop_p,
    input  logic snooze_p,
    input  logic start_p,
    input  logic ld_any,
    output logic tone,
    output logic relay
);
    localparam int CNT_W = $clog2(SNOOZE_BASE + (1 << JIT_W) + 1);

    logic [LFSR_W-1:0] lfsr_q;
    logic [CNT_W-1:0]  snz_q, snz_n;
    logic              tone_q, tone_n, relay_q, relay_n;
    logic              match;

    assign match = sec_upd && armed && today_ok && (now == today);

    always_comb begin
        tone_n  = tone_q;
        relay_n = relay_q;
        snz_n   = snz_q;
        if (sec_upd && snz_q != '0) begin
            snz_n = snz_q - CNT_W'(1);
            if (snz_q == CNT_W'(1)) tone_n = 1'b1;
        end
        if (match) begin
            tone_n  = 1'b1;
            relay_n = 1'b1;
            snz_n   = '0;
        end
        if (snooze_p && tone_q) begin
            tone_n = 1'b0;
            snz_n  = CNT_W'(SNOOZE_BASE) + CNT_W'(lfsr_q[JIT_W-1:0]);
        end
        if (start_p) relay_n = 1'b1;
        if (stop_p) begin
            if (tone_q || snz_q != '0) begin
                tone_n = 1'b0;
                snz_n  = '0;
            end else begin
                relay_n = 1'b0;
            end
        end
        if (ld_any) snz_n = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr_q  <= LFSR_W'(1);
            snz_q   <= '0;
            tone_q  <= 1'b0;
            relay_q <= 1'b0;
        end else begin
            lfsr_q  <= {lfsr_q[LFSR_W-2:0], ^(lfsr_q & LFSR_TAPS)};
            snz_q   <= snz_n;
            tone_q  <= tone_n;
            relay_q <= relay_n;
        end
    end

    assign tone  = tone_q;
    assign relay = relay_q;

    // R4: a sounding tone always has the relay closed
    a_r4_tone_has_relay: assert property (@(posedge clk) disable iff (rst)
        tone_q |-> relay_q);
    // R5: only a stop press can drop the relay
    a_r5_relay_held: assert property (@(posedge clk) disable iff (rst)
        (relay_q && !stop_p) |=> relay_q);
    // R6: stop always leaves the tone silent
    a_r6_stop_mutes: assert property (@(posedge clk) disable iff (rst)
        stop_p |=> !tone_q);
    // R8: silent while a snooze is pending
    a_r8_snooze_quiet: assert property (@(posedge clk) disable iff (rst)
        (snz_q != '0) |-> !tone_q);
    // R8: the shift register never locks up at zero
    a_r8_lfsr_live: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);

endmodule

// File: rtl/wk_alarm_ctrl.sv
`timescale 1ns/1ps
module wk_alarm_ctrl
    import wk_alarm_pkg::*;
#(
    parameter bit BTN_ACTIVE_LOW = 1'b0,
    parameter bit ARM_LATCHING   = 1'b0,
    parameter int SNOOZE_BASE    = 180,
    parameter int JIT_W          = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sec_tick,
    input  logic                 btn_stop,
    input  logic                 btn_snooze,
    input  logic                 btn_start,
    input  logic                 arm_in,
    input  logic [WK_SLOT_W-1:0] day_of_week,
    input  logic                 ld_valid,
    input  logic [WK_SLOT_W-1:0] ld_slot,
    input  logic [7:0]           ld_hh,
    input  logic [7:0]           ld_mm,
    input  logic [7:0]           ld_ss,
    output logic                 tone_en,
    output logic                 relay_out,
    output logic                 armed,
    output logic [7:0]           now_hh,
    output logic [7:0]           now_mm,
    output logic [7:0]           now_ss
);
    logic [WK_NBTN-1:0] raw, press;
    hms_t               ld_val, now, today;
    logic               ld_time, sec_upd, today_ok, arm_lvl, armed_q;

    assign raw[BTN_STOP]   = btn_stop;
    assign raw[BTN_SNOOZE] = btn_snooze;
    assign raw[BTN_START]  = btn_start;
    assign raw[BTN_ARM]    = arm_in;
    assign arm_lvl         = arm_in ^ BTN_ACTIVE_LOW;
    assign ld_val          = '{hh: ld_hh, mm: ld_mm, ss: ld_ss};
    assign ld_time         = ld_valid && (ld_slot == WK_SLOT_CLOCK);

    wk_btn_cond #(.N(WK_NBTN), .ACTIVE_LOW(BTN_ACTIVE_LOW)) btn_i (
        .clk(clk), .rst(rst), .raw(raw), .press(press));

    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= ARM_LATCHING ? arm_lvl : (armed_q ^ press[BTN_ARM]);
    end

    wk_timekeeper time_i (
        .clk(clk), .rst(rst), .tick(sec_tick), .ld_en(ld_time),
        .ld_val(ld_val), .now(now), .sec_upd(sec_upd));

    wk_alarm_bank bank_i (
        .clk(clk), .rst(rst), .ld_en(ld_valid), .ld_slot(ld_slot),
        .ld_val(ld_val), .day(day_of_week), .today(today), .today_ok(today_ok));

    wk_ring_ctl #(.SNOOZE_BASE(SNOOZE_BASE), .JIT_W(JIT_W)) ring_i (
        .clk(clk), .rst(rst), .sec_upd(sec_upd), .armed(armed_q),
        .today_ok(today_ok), .today(today), .now(now),
        .stop_p(press[BTN_STOP]), .snooze_p(press[BTN_SNOOZE]),
        .start_p(press[BTN_START]), .ld_any(ld_valid),
        .tone(tone_en), .relay(relay_out));

    assign armed  = armed_q;
    assign now_hh = now.hh;
    assign now_mm = now.mm;
    assign now_ss = now.ss;

    // R10: disarmed means no new alarm can start the tone
    a_r10_disarmed_silent: assert property (@(posedge clk) disable iff (rst)
        (!armed_q && !tone_en && !press[BTN_SNOOZE] && !relay_out) |=> !tone_en);

endmodule

// File: tb/wk_alarm_ctrl_tb_top.sv
`timescale 1ns/1ps
module wk_alarm_ctrl_tb_top;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst = 1'b1, tick = 1'b0, ldv = 1'b0;
    logic [2:0] day = 3'd7, slot = 3'd0;
    logic [7:0] lh = 8'h00, lm = 8'h00, ls = 8'h00;
    logic       stop_a = 1'b0, snz_a = 1'b0, start_a = 1'b0, arm_a = 1'b0;
    logic       stop_b = 1'b1, snz_b = 1'b1, start_b = 1'b1, arm_b = 1'b1;
    logic [2:0] day_b = 3'd7;
    logic       tone_a, relay_a, armed_a, tone_b, relay_b, armed_b;
    logic [7:0] hh_a, mm_a, ss_a, hh_b, mm_b, ss_b;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    wk_alarm_ctrl dut_i (
        .clk(clk), .rst(rst), .sec_tick(tick), .btn_stop(stop_a), .btn_snooze(snz_a),
        .btn_start(start_a), .arm_in(arm_a), .day_of_week(day), .ld_valid(ldv),
        .ld_slot(slot), .ld_hh(lh), .ld_mm(lm), .ld_ss(ls), .tone_en(tone_a),
        .relay_out(relay_a), .armed(armed_a), .now_hh(hh_a), .now_mm(mm_a), .now_ss(ss_a));

    wk_alarm_ctrl #(.BTN_ACTIVE_LOW(1'b1), .ARM_LATCHING(1'b1)) dut_b_i (
        .clk(clk), .rst(rst), .sec_tick(tick), .btn_stop(stop_b), .btn_snooze(snz_b),
        .btn_start(start_b), .arm_in(arm_b), .day_of_week(day_b), .ld_valid(ldv),
        .ld_slot(slot), .ld_hh(lh), .ld_mm(lm), .ld_ss(ls), .tone_en(tone_b),
        .relay_out(relay_b), .armed(armed_b), .now_hh(hh_b), .now_mm(mm_b), .now_ss(ss_b));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] to_bcd(input int s);
        int h = s / 3600;
        int m = (s / 60) % 60;
        int x = s % 60;
        return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10), 4'(x / 10), 4'(x % 10)};
    endfunction

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic load(input logic [2:0] s, input logic [23:0] v);
        ldv = 1'b1; slot = s; {lh, lm, ls} = v;
        @(negedge clk) ldv = 1'b0;
        @(negedge clk);
    endtask

    // 0 stop, 1 snooze, 2 start, 3 arm (dut_i); 4 stop on dut_b_i (active low)
    task automatic press(input int which);
        case (which)
            0: stop_a = 1'b1;
            1: snz_a = 1'b1;
            2: start_a = 1'b1;
            3: arm_a = 1'b1;
            default: stop_b = 1'b0;
        endcase
        @(negedge clk);
        stop_a = 1'b0; snz_a = 1'b0; start_a = 1'b0; arm_a = 1'b0; stop_b = 1'b1;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
        end
    end

    initial begin
        int k;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset time", {hh_a, mm_a, ss_a}, 24'h000000);
        chk("R4 reset tone/relay", {tone_a, relay_a}, 2'b00);
        chk("R10 reset armed", armed_a, 1'b0);

        load(3'd7, 24'h225800);
        chk("R2 clock load", {hh_a, mm_a, ss_a}, 24'h225800);
        for (int i = 1; i <= 3700; i++) begin
            ticks(1);
            chk("R1 count sweep", {hh_a, mm_a, ss_a}, to_bcd((82680 + i) % 86400));
        end

        tick = 1'b1; ldv = 1'b1; slot = 3'd7; {lh, lm, ls} = 24'h123456;
        @(negedge clk) begin tick = 1'b0; ldv = 1'b0; end
        @(negedge clk);
        chk("R2 load beats tick", {hh_a, mm_a, ss_a}, 24'h123456);
        ticks(1);
        chk("R2 count after load", {hh_a, mm_a, ss_a}, 24'h123457);

        press(3); chk("R10 toggle on", armed_a, 1'b1);
        press(3); chk("R10 toggle off", armed_a, 1'b0);
        press(3); chk("R10 toggle on again", armed_a, 1'b1);

        load(3'd3, 24'h073000);
        load(3'd5, 24'h090000);
        day = 3'd3;
        load(3'd7, 24'h072959);
        chk("R4 before match", {tone_a, relay_a}, 2'b00);
        ticks(1);
        chk("R4 R3 fire day3", {tone_a, relay_a}, 2'b11);
        press(0); chk("R6 first stop", {tone_a, relay_a}, 2'b01);
        ticks(3); chk("R5 relay held", {tone_a, relay_a}, 2'b01);
        press(0); chk("R6 second stop", {tone_a, relay_a}, 2'b00);

        day = 3'd5;
        load(3'd7, 24'h072959); ticks(1);
        chk("R3 other day silent", {tone_a, relay_a}, 2'b00);
        load(3'd7, 24'h085959); ticks(1);
        chk("R3 fire day5", {tone_a, relay_a}, 2'b11);
        press(0); press(0);

        load(3'd7, 24'h090000);
        chk("R11 load equal no fire", {tone_a, relay_a}, 2'b00);
        ticks(1);
        chk("R11 next second no fire", {tone_a, relay_a}, 2'b00);

        press(3);
        load(3'd7, 24'h085959); ticks(1);
        chk("R10 disarmed silent", {armed_a, tone_a, relay_a}, 3'b000);
        press(3);

        press(2); chk("R7 start relay only", {tone_a, relay_a}, 2'b01);
        press(0); chk("R7 R6 stop clears relay", {tone_a, relay_a}, 2'b00);

        load(3'd7, 24'h085959); ticks(1);
        chk("R8 fire", {tone_a, relay_a}, 2'b11);
        press(1); chk("R8 snooze mutes", {tone_a, relay_a}, 2'b01);
        ticks(179); chk("R8 still muted at 179", {tone_a, relay_a}, 2'b01);
        k = 179;
        while (!tone_a && k < 200) begin ticks(1); k++; end
        n_chk++;
        if (k < 180 || k > 195) begin
            n_fail++;
            $display("FAIL R8 resound delay actual=%0d expected=180..195", k);
        end
        chk("R8 relay through snooze", relay_a, 1'b1);
        press(0);
        press(1); ticks(200);
        chk("R8 snooze ignored when silent", {tone_a, relay_a}, 2'b01);
        press(0); chk("R6 relay off", relay_a, 1'b0);

        load(3'd7, 24'h085959); ticks(1);
        press(1); ticks(10);
        load(3'd6, 24'h000000);
        ticks(200);
        chk("R12 load cancels snooze", {tone_a, relay_a}, 2'b01);
        press(0);

        day = 3'd7;
        load(3'd7, 24'h085959); ticks(1);
        chk("R3 no-day silent", {tone_a, relay_a}, 2'b00);

        chk("R10 latching idle", armed_b, 1'b0);
        arm_b = 1'b0; @(negedge clk); @(negedge clk);
        chk("R10 R9 latching low=armed", armed_b, 1'b1);
        load(3'd0, 24'h000005);
        load(3'd7, 24'h000004);
        day_b = 3'd0;
        ticks(1);
        chk("R9 fire active-low unit", {tone_b, relay_b}, 2'b11);
        press(4);
        chk("R9 active-low stop", {tone_b, relay_b}, 2'b01);
        arm_b = 1'b1; @(negedge clk); @(negedge clk);
        chk("R10 latching released", armed_b, 1'b0);

        done = 1'b1;
        summary();
    end
endmodule